// File: doc/BRIEF.md
# TDM serial audio slot interface

This block is a synchronous serial audio port that works as a slave to an external codec in time-slot mode. The codec drives the bit clock and a one-bit-wide, active-high frame sync. The sync occupies the bit period just before the first data bit of each frame. A frame is 32 bit clocks long and holds two 16-bit slots: the left slot comes first, then the right slot. Data moves MSB first. Outgoing bits change after a rising bit-clock edge. Incoming bits are sampled on a falling edge. The nominal bit clock is 768 kHz, which is 12.288 MHz divided by 16.

On the parallel side, each slot appears as a 24-bit word. The 16 slot bits sit at bits 23..8 and bits 7..0 are zero. Surrounding logic loads the next pair of outgoing words with a load strobe. It reads the received pair after a one-cycle frame-done pulse and then acknowledges them with a read strobe. A transmit underrun flag and a receive overrun flag report missed service. A clear strobe resets both flags.

The bit clock, frame sync and serial input each pass through a two-flop synchronizer before the system-clock logic detects edges on them. The receive and transmit slot pointers step modulo 2. Each pointer is forced home at the last slot of a frame, so a pointer disturbed by a short frame recovers within one frame.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, sdout, frame_done, tx_underrun and rx_overrun are 0, and rx_left and rx_right are all zeros.
- R2: A frame starts with the bit period that follows a falling bit-clock edge at which fsync was sampled high. With no such sync, the port captures nothing, gives no frame_done and holds sdout at 0.
- R3: The port samples received bits at falling edges, MSB first. Frame bits 0..15 go to rx_left[23:8] and bits 16..31 go to rx_right[23:8]. Bits 7..0 of both words read 0.
- R4: sdout changes only after a rising bit-clock edge. Frame bits 0..15 carry tx_left[23:8] MSB first, and bits 16..31 carry tx_right[23:8]. The low bytes tx_left[7:0] and tx_right[7:0] are never sent. Outside a frame, sdout is 0.
- R5: frame_done is a pulse one system clock wide. It is raised once per complete frame, after the right slot has been captured.
- R6: The port sets tx_underrun when a slot starts and no tx_load has occurred since that slot's word was last used. In that case the previous word is sent again.
- R7: The port sets rx_overrun when it writes a received word into a slot register that has not been acknowledged by rx_read since its last write. The register still takes the new word.
- R8: A status_clr pulse clears both tx_underrun and rx_overrun.
- R9: The slot pointers step modulo 2 and return to slot 0 at the last slot of a frame. A frame sync in the middle of a frame restarts the bit count. After a frame cut short inside slot 1, the next received frame lands swapped (right data in rx_left, left data in rx_right). After a frame cut short inside slot 0, the next transmitted frame sends tx_right's word first and tx_left's word second. The frame after that is correct again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the codec |
| fsync | input | 1 | Frame sync from the codec, one bit period wide, active high |
| sdin | input | 1 | Serial data from the codec |
| sdout | output | 1 | Serial data to the codec |
| tx_left | input | 24 | Next left word; bits 23..8 are sent |
| tx_right | input | 24 | Next right word; bits 23..8 are sent |
| tx_load | input | 1 | Strobe that captures tx_left and tx_right |
| rx_left | output | 24 | Last received left word, left-aligned |
| rx_right | output | 24 | Last received right word, left-aligned |
| rx_read | input | 1 | Strobe that marks both received words as read |
| frame_done | output | 1 | One-clock pulse after the right slot is captured |
| status_clr | input | 1 | Strobe that clears both error flags |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
A wrong bit counter or arming state shows up at once as misplaced bits on sdout in the same frame. It also shows up as a missing or extra frame_done within one frame time. A slot pointer left in the wrong state shows up as swapped words in the very next frame, on rx_left/rx_right and on sdout. The bench forces this condition with frames cut short at each slot and expects the frame after to be correct again. Wrong pending or unread bookkeeping shows up as an error flag that rises one slot too early, one slot too late, or never, against skipped loads and skipped reads.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // One decoded bit-clock event, in the system clock domain
  typedef struct packed {
    logic rise;   // bit clock rose this cycle
    logic fall;   // bit clock fell this cycle
    logic fs;     // synchronized frame sync level
    logic din;    // synchronized serial input level
  } bit_evt_t;

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync
  import tdm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bclk,
  input  logic     fsync,
  input  logic     sdin,
  output bit_evt_t evt
);

  localparam int LAST = STAGES - 1;

  // bit 0: bit clock, bit 1: frame sync, bit 2: serial input
  logic [STAGES-1:0][2:0] chain_q, chain_d;
  logic                   bclk_prev_q, bclk_prev_d;

  always_comb begin
    chain_d     = {chain_q[STAGES-2:0], {sdin, fsync, bclk}};
    bclk_prev_d = chain_q[LAST][0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q     <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      chain_q     <= chain_d;
      bclk_prev_q <= bclk_prev_d;
    end
  end

  always_comb begin
    evt.rise = chain_q[LAST][0] & ~bclk_prev_q;
    evt.fall = ~chain_q[LAST][0] & bclk_prev_q;
    evt.fs   = chain_q[LAST][1];
    evt.din  = chain_q[LAST][2];
  end

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_pkg::*;
#(
  parameter int SLOT_BITS = 16,
  parameter int WORD_BITS = 24,
  parameter int SLOTS     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  bit_evt_t                        evt,
  input  logic                            rd_clr,
  input  logic                            st_clr,
  output logic [SLOTS-1:0][WORD_BITS-1:0] words,
  output logic                            frame_done,
  output logic                            overrun
);

  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int SB_W       = $clog2(SLOT_BITS);
  localparam int PTR_W      = $clog2(SLOTS);
  localparam int PAD        = WORD_BITS - SLOT_BITS;

  logic                 armed_q, armed_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [SLOT_BITS-1:0] shreg_q, shreg_d;
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic [SLOTS-1:0]     unread_q, unread_d;
  logic                 ovr_q, ovr_d;
  logic                 done_q, done_d;
  logic [WORD_BITS-1:0] buf_q [SLOTS];

  logic                 sample, slot_end, last_slot, ovr_set;
  logic [SLOTS-1:0]     wr_vec;
  logic [WORD_BITS-1:0] word_d;
  logic                 unused_rise;

  assign unused_rise = evt.rise;

  always_comb begin
    sample    = evt.fall & armed_q;
    slot_end  = sample && (idx_q[SB_W-1:0] == SB_W'(SLOT_BITS - 1));
    last_slot = (idx_q[IDX_W-1:SB_W] == PTR_W'(SLOTS - 1));
    word_d    = {shreg_q[SLOT_BITS-2:0], evt.din, {PAD{1'b0}}};

    shreg_d = sample ? {shreg_q[SLOT_BITS-2:0], evt.din} : shreg_q;

    armed_d = armed_q;
    idx_d   = idx_q;
    if (evt.fall && evt.fs) begin
      armed_d = 1'b1;
      idx_d   = '0;
    end else if (sample) begin
      idx_d = idx_q + IDX_W'(1);
      if (idx_q == IDX_W'(FRAME_BITS - 1)) armed_d = 1'b0;
    end

    ptr_d = ptr_q;
    if (slot_end) begin
      if (last_slot || ptr_q == PTR_W'(SLOTS - 1)) ptr_d = '0;
      else                                         ptr_d = ptr_q + PTR_W'(1);
    end

    for (int i = 0; i < SLOTS; i++) begin
      wr_vec[i] = slot_end && (ptr_q == PTR_W'(i));
    end
    unread_d = wr_vec | (unread_q & ~{SLOTS{rd_clr}});
    ovr_set  = |(wr_vec & unread_q & ~{SLOTS{rd_clr}});
    ovr_d    = ovr_set | (ovr_q & ~st_clr);
    done_d   = slot_end & last_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      idx_q    <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      unread_q <= '0;
      ovr_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      idx_q    <= idx_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      unread_q <= unread_d;
      ovr_q    <= ovr_d;
      done_q   <= done_d;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         buf_q[i] <= '0;
      else if (wr_vec[i]) buf_q[i] <= word_d;
    end
    assign words[i] = buf_q[i];
  end

  assign frame_done = done_q;
  assign overrun    = ovr_q;

  // R5: the frame-done strobe never lasts more than one clock
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: overrun only rises after a slot write
  assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(|wr_vec));

  // R9: after the last slot is captured, the pointer is home
  assert_rx_ptr_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && last_slot) |=> (ptr_q == '0));

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
  import tdm_pkg::*;
#(
  parameter int SLOT_BITS = 16,
  parameter int WORD_BITS = 24,
  parameter int SLOTS     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  bit_evt_t                        evt,
  input  logic                            ld,
  input  logic [SLOTS-1:0][WORD_BITS-1:0] words,
  input  logic                            st_clr,
  output logic                            sdout,
  output logic                            underrun
);

  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int SB_W       = $clog2(SLOT_BITS);
  localparam int PTR_W      = $clog2(SLOTS);
  localparam int PAD        = WORD_BITS - SLOT_BITS;

  logic                 start_q, start_d;
  logic                 active_q, active_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [SLOT_BITS-1:0] shreg_q, shreg_d;
  logic                 sdout_q, sdout_d;
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic [SLOTS-1:0]     pend_q, pend_d;
  logic                 udr_q, udr_d;
  logic [SLOT_BITS-1:0] tbuf_q [SLOTS];

  logic                 emit, slot_begin, last_slot, udr_set;
  logic [IDX_W-1:0]     bit_idx;
  logic [SLOT_BITS-1:0] sel_word;
  logic [SLOTS-1:0]     use_vec;
  logic [SLOTS*PAD-1:0] unused_low;
  logic                 unused_din;

  assign unused_din = evt.din;
  for (genvar i = 0; i < SLOTS; i++) begin : g_low
    assign unused_low[i*PAD +: PAD] = words[i][PAD-1:0];
  end

  always_comb begin
    start_d = start_q;
    if (evt.fall && evt.fs) start_d = 1'b1;
    else if (evt.rise)      start_d = 1'b0;

    emit       = evt.rise && (start_q || active_q);
    bit_idx    = start_q ? '0 : idx_q;
    slot_begin = emit && (bit_idx[SB_W-1:0] == '0);
    last_slot  = (bit_idx[IDX_W-1:SB_W] == PTR_W'(SLOTS - 1));
    sel_word   = tbuf_q[ptr_q];

    sdout_d  = sdout_q;
    shreg_d  = shreg_q;
    idx_d    = idx_q;
    active_d = active_q;
    if (emit) begin
      if (slot_begin) begin
        sdout_d = sel_word[SLOT_BITS-1];
        shreg_d = {sel_word[SLOT_BITS-2:0], 1'b0};
      end else begin
        sdout_d = shreg_q[SLOT_BITS-1];
        shreg_d = {shreg_q[SLOT_BITS-2:0], 1'b0};
      end
      idx_d    = bit_idx + IDX_W'(1);
      active_d = (bit_idx != IDX_W'(FRAME_BITS - 1));
    end else if (evt.rise) begin
      sdout_d  = 1'b0;
      active_d = 1'b0;
    end

    ptr_d = ptr_q;
    if (slot_begin) begin
      if (last_slot || ptr_q == PTR_W'(SLOTS - 1)) ptr_d = '0;
      else                                         ptr_d = ptr_q + PTR_W'(1);
    end

    for (int i = 0; i < SLOTS; i++) begin
      use_vec[i] = slot_begin && (ptr_q == PTR_W'(i));
    end
    pend_d  = {SLOTS{ld}} | (pend_q & ~use_vec);
    udr_set = |(use_vec & ~pend_q);
    udr_d   = udr_set | (udr_q & ~st_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      active_q <= 1'b0;
      idx_q    <= '0;
      shreg_q  <= '0;
      sdout_q  <= 1'b0;
      ptr_q    <= '0;
      pend_q   <= '0;
      udr_q    <= 1'b0;
    end else begin
      start_q  <= start_d;
      active_q <= active_d;
      idx_q    <= idx_d;
      shreg_q  <= shreg_d;
      sdout_q  <= sdout_d;
      ptr_q    <= ptr_d;
      pend_q   <= pend_d;
      udr_q    <= udr_d;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tbuf_q[i] <= '0;
      else if (ld) tbuf_q[i] <= words[i][WORD_BITS-1 -: SLOT_BITS];
    end
  end

  assign sdout    = sdout_q;
  assign underrun = udr_q;

  // R4: the serial output only moves in the cycle after a rising bit clock
  assert_sdout_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.rise |=> $stable(sdout_q));

  // R6: underrun only rises after a slot has started
  assert_udr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_q) |-> $past(slot_begin));

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_pkg::*;
#(
  parameter int SLOT_BITS   = 16,
  parameter int WORD_BITS   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk,
  input  logic                 fsync,
  input  logic                 sdin,
  output logic                 sdout,
  input  logic [WORD_BITS-1:0] tx_left,
  input  logic [WORD_BITS-1:0] tx_right,
  input  logic                 tx_load,
  output logic [WORD_BITS-1:0] rx_left,
  output logic [WORD_BITS-1:0] rx_right,
  input  logic                 rx_read,
  output logic                 frame_done,
  input  logic                 status_clr,
  output logic                 tx_underrun,
  output logic                 rx_overrun
);

  localparam int SLOTS = 2;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  bit_evt_t                        evt;
  logic [SLOTS-1:0][WORD_BITS-1:0] rx_words;
  logic [SLOTS-1:0][WORD_BITS-1:0] tx_words;

  assign tx_words = {tx_right, tx_left};

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .bclk  (bclk),
    .fsync (fsync),
    .sdin  (sdin),
    .evt   (evt)
  );

  tdm_rx_deser #(.SLOT_BITS(SLOT_BITS), .WORD_BITS(WORD_BITS), .SLOTS(SLOTS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .evt        (evt),
    .rd_clr     (rx_read),
    .st_clr     (status_clr),
    .words      (rx_words),
    .frame_done (frame_done),
    .overrun    (rx_overrun)
  );

  tdm_tx_ser #(.SLOT_BITS(SLOT_BITS), .WORD_BITS(WORD_BITS), .SLOTS(SLOTS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .evt      (evt),
    .ld       (tx_load),
    .words    (tx_words),
    .st_clr   (status_clr),
    .sdout    (sdout),
    .underrun (tx_underrun)
  );

  assign rx_left  = rx_words[0];
  assign rx_right = rx_words[1];

endmodule

// File: tb/tdm_slot_port_bench.sv
module tdm_slot_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic        sdout;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic        tx_load = 1'b0, rx_read = 1'b0, status_clr = 1'b0;
  logic [23:0] rx_left, rx_right;
  logic        frame_done, tx_underrun, rx_overrun;

  int errors = 0;
  int checks = 0;
  int fd_cnt = 0;
  logic [23:0] pend_l, pend_r;
  logic [15:0] last_rl, last_rr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_port u_tdm_slot_port (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
    .sdout(sdout), .tx_left(tx_left), .tx_right(tx_right), .tx_load(tx_load),
    .rx_left(rx_left), .rx_right(rx_right), .rx_read(rx_read),
    .frame_done(frame_done), .status_clr(status_clr),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
  );

  always @(posedge clk) if (rst_n && frame_done) fd_cnt++;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic half_high(input logic d, input logic fs, output logic so);
    bclk = 1'b1; sdin = d; fsync = fs;
    repeat (HALF-1) @(negedge clk);
    so = sdout;
    @(negedge clk);
  endtask

  task automatic half_low(input logic ld, input logic rd, input logic cl);
    bclk = 1'b0;
    @(negedge clk);
    tx_load = ld; rx_read = rd; status_clr = cl;
    @(negedge clk);
    tx_load = 1'b0; rx_read = 1'b0; status_clr = 1'b0;
    repeat (HALF-2) @(negedge clk);
  endtask

  task automatic run_frame(input int nbits, input bit sync_end, input int load_at,
                           input logic [23:0] nl, input logic [23:0] nr,
                           input int read_at, input int clr_at,
                           input logic [15:0] rl, input logic [15:0] rr,
                           output logic [31:0] got);
    logic [31:0] bits;
    logic so;
    bits = {rl, rr};
    got  = '0;
    for (int b = 0; b < nbits; b++) begin
      half_high(bits[31-b], sync_end && (b == nbits-1), so);
      got[31-b] = so;
      if (b == load_at) begin tx_left = nl; tx_right = nr; end
      half_low(b == load_at, b == read_at, b == clr_at);
    end
  endtask

  // complete frame with full checking of tx, rx and frame_done
  task automatic std_frame(input bit do_load, input bit do_read, input bit do_clr,
                           input bit sync_end);
    logic [15:0] rl, rr;
    logic [23:0] nl, nr;
    logic [31:0] got, exp_tx;
    int fd0;
    rl = 16'($urandom); rr = 16'($urandom);
    nl = 24'($urandom); nr = 24'($urandom);
    exp_tx = {pend_l[23:8], pend_r[23:8]};
    fd0 = fd_cnt;
    run_frame(32, sync_end, do_load ? 18 : -1, nl, nr, do_read ? 4 : -1,
              do_clr ? 2 : -1, rl, rr, got);
    if (do_load) begin pend_l = nl; pend_r = nr; end
    chk("R4 sdout slot bits", 64'(got), 64'(exp_tx));
    chk("R3 rx_left word", 64'(rx_left), 64'({rl, 8'h00}));
    chk("R3 rx_right word", 64'(rx_right), 64'({rr, 8'h00}));
    chk("R5 one frame_done per frame", 64'(fd_cnt - fd0), 64'(1));
    last_rl = rl; last_rr = rr;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic so;
    logic [15:0] rl, rr;
    logic [23:0] nl, nr, ml, mr;
    logic [31:0] got, exp_tx;
    int fd0;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 sdout", 64'(sdout), 64'(0));
    chk("R1 frame_done", 64'(frame_done), 64'(0));
    chk("R1 tx_underrun", 64'(tx_underrun), 64'(0));
    chk("R1 rx_overrun", 64'(rx_overrun), 64'(0));
    chk("R1 rx_left", 64'(rx_left), 64'(0));
    chk("R1 rx_right", 64'(rx_right), 64'(0));

    // first words, then the sync-only preamble bit
    pend_l = 24'($urandom); pend_r = 24'($urandom);
    tx_left = pend_l; tx_right = pend_r; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
    half_high(1'b0, 1'b1, so);
    chk("R4 sdout idle before frame", 64'(so), 64'(0));
    half_low(1'b0, 1'b0, 1'b0);

    // R3 R4 R5 normal random traffic
    repeat (5) std_frame(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R6 no underrun in serviced traffic", 64'(tx_underrun), 64'(0));
    chk("R7 no overrun in serviced traffic", 64'(rx_overrun), 64'(0));

    // R6 underrun: skip one load, next frame resends old words
    std_frame(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 underrun not yet", 64'(tx_underrun), 64'(0));
    std_frame(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R6 underrun raised", 64'(tx_underrun), 64'(1));
    std_frame(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R8 underrun cleared", 64'(tx_underrun), 64'(0));

    // R7 overrun: skip one read
    std_frame(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R7 overrun raised", 64'(rx_overrun), 64'(1));
    std_frame(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R8 overrun cleared", 64'(rx_overrun), 64'(0));

    // R9 receive pointer recovery: frame cut inside slot 1
    rl = 16'($urandom); rr = 16'($urandom);
    nl = 24'($urandom); nr = 24'($urandom);
    fd0 = fd_cnt;
    run_frame(20, 1'b1, 18, nl, nr, 4, -1, rl, rr, got);
    pend_l = nl; pend_r = nr;
    chk("R9 no frame_done on cut frame", 64'(fd_cnt - fd0), 64'(0));
    rl = 16'($urandom); rr = 16'($urandom);
    ml = 24'($urandom); mr = 24'($urandom);
    exp_tx = {pend_l[23:8], pend_r[23:8]};
    run_frame(32, 1'b1, 18, ml, mr, 4, -1, rl, rr, got);
    pend_l = ml; pend_r = mr;
    chk("R9 tx intact after rx cut", 64'(got), 64'(exp_tx));
    chk("R9 rx_left swapped once", 64'(rx_left), 64'({rr, 8'h00}));
    chk("R9 rx_right swapped once", 64'(rx_right), 64'({rl, 8'h00}));
    std_frame(1'b1, 1'b1, 1'b1, 1'b1);

    // R9 transmit pointer recovery: frame cut inside slot 0
    rl = 16'($urandom); rr = 16'($urandom);
    nl = 24'($urandom); nr = 24'($urandom);
    fd0 = fd_cnt;
    run_frame(10, 1'b1, 5, nl, nr, 4, -1, rl, rr, got);
    chk("R9 no frame_done on short frame", 64'(fd_cnt - fd0), 64'(0));
    rl = 16'($urandom); rr = 16'($urandom);
    ml = 24'($urandom); mr = 24'($urandom);
    exp_tx = {nr[23:8], nl[23:8]};
    run_frame(32, 1'b1, 18, ml, mr, 4, -1, rl, rr, got);
    pend_l = ml; pend_r = mr;
    chk("R9 tx words swapped once", 64'(got), 64'(exp_tx));
    chk("R9 rx_left intact", 64'(rx_left), 64'({rl, 8'h00}));
    chk("R9 rx_right intact", 64'(rx_right), 64'({rr, 8'h00}));
    std_frame(1'b1, 1'b1, 1'b1, 1'b0);

    // R2 no frame sync: nothing happens
    rl = 16'($urandom); rr = 16'($urandom);
    fd0 = fd_cnt;
    run_frame(32, 1'b0, -1, 24'h0, 24'h0, -1, -1, rl, rr, got);
    chk("R2 sdout idle without sync", 64'(got), 64'(0));
    chk("R2 no frame_done without sync", 64'(fd_cnt - fd0), 64'(0));
    chk("R2 rx_left unchanged", 64'(rx_left), 64'({last_rl, 8'h00}));
    chk("R2 rx_right unchanged", 64'(rx_right), 64'({last_rr, 8'h00}));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule